// File: doc/BRIEF.md
# Page-CRC memory read sequencer

This block is the byte-level engine behind a read command in a serial read-only memory slave. The bit-level front end strobes `seq_start_i` once the bus has been initialised and the address-skip step is done. The sequencer then takes one function byte. If that byte is the page-CRC read opcode, the sequencer takes a two-byte start address, low byte first. It then answers byte requests from the host side in this order: first a check byte over the header, then the stored bytes in ascending order. After the last byte of each 32-byte page it inserts a generated check byte. After the check byte of the final page, it keeps returning all-ones bytes.

The storage is 128 bytes organised as four pages, so each page appears on the wire as 33 bytes. The storage is reached through a synchronous read port with one cycle of latency. Every check byte is an 8-bit CRC with polynomial x^8+x^5+x^4+1. The CRC processes each byte least-significant bit first, which matches the order in which bytes travel on the wire, and it starts from zero. A bus reset abandons any sequence at once. The host uses this when the header check byte it reads back is wrong.

Top module: `page_crc_reader`

## Requirements
- R1: After `rst_ni` or `bus_reset_i`, `tx_valid_o` is low and `mem_rd_o` is low until a request arrives. A byte request made outside a header-CRC, data or page-CRC phase returns FFh.
- R2: The first byte received after `seq_start_i` is compared with opcode C3h. Any other value returns the block to waiting for `seq_start_i`. Later bytes are then ignored and requests return FFh.
- R3: After C3h, the next received byte is address bits 7..0 and the byte after it is address bits 15..8. The first byte returned is CRC8(C3h, low, high), computed LSB first with reflected polynomial 8Ch and initial value 00h.
- R4: With a valid address, data bytes are returned from storage starting at the start address and ascending by one. The read port `mem_addr_o` carries the index of the byte being fetched.
- R5: After the byte at an index whose low five bits are 11111b, one extra byte is returned. That byte is the CRC of the data bytes returned since the previous check byte (or since the start address), ending with the page's last byte.
- R6: After a page check byte, output resumes at the first byte of the next page with the CRC cleared to 00h.
- R7: After the check byte of page 3 (index 127), every further request returns FFh until a reset.
- R8: If any of address bits 15..7 is set, the header check byte is still returned. Every later request then returns FFh, no page check byte is inserted, and `mem_rd_o` never rises.
- R9: `bus_reset_i` at any point aborts the sequence. Header state is discarded and the block waits for `seq_start_i` again.
- R10: A request with no response pending gets its response on `tx_valid_o` in the next cycle, for exactly one cycle. No response appears without a request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| bus_reset_i | input | 1 | Bus reset seen on the wire; aborts the sequence |
| seq_start_i | input | 1 | Initialisation and address-skip done; arms opcode reception |
| rx_valid_i | input | 1 | A received byte is present |
| rx_data_i | input | 8 | Received byte |
| tx_req_i | input | 1 | Host side asks for the next byte |
| tx_valid_o | output | 1 | Response byte valid |
| tx_data_o | output | 8 | Response byte |
| mem_rd_o | output | 1 | Storage read strobe |
| mem_addr_o | output | 7 | Storage byte index |
| mem_data_i | input | 8 | Storage read data, one cycle after the strobe |

## Verification
The bench aims at three kinds of corner cases. The first is page seams: a start in mid-page, a start at index 127, and the wrap after the last page. A design with an off-by-one page test would insert the check byte one byte late or early, and one that forgot to clear the CRC would return a check byte that mixes pages. The second is invalid headers: a wrong opcode, and addresses with bit 7 or a high-byte bit set. A design that did not catch these would read storage through an aliased index and insert page check bytes where only FFh belongs. The third is bus resets in the middle of the header and in the middle of the data. A design that kept partial header CRC state would return a wrong header check byte on the retry.

// File: rtl/page_crc_pkg.sv
package page_crc_pkg;
  typedef enum logic [3:0] {
    ST_IDLE, ST_CMD, ST_ALO, ST_AHI, ST_HCRC, ST_DATA, ST_PCRC, ST_DONE, ST_FILL
  } seq_state_e;

  typedef enum logic [1:0] {SRC_FILL, SRC_MEM, SRC_CRC} tx_src_e;

  localparam logic [7:0] CRC_POLY_REFL = 8'h8C;
endpackage

// File: rtl/crc8_lsb.sv
module crc8_lsb #(
  parameter int W = 8,
  parameter logic [W-1:0] POLY = 8'h8C
) (
  input  logic [W-1:0] crc_i,
  input  logic [W-1:0] data_i,
  output logic [W-1:0] crc_o
);
  logic [W:0][W-1:0] stage;

  assign stage[0] = crc_i;
  for (genvar i = 0; i < W; i++) begin : g_bit
    assign stage[i+1] = (stage[i] >> 1) ^ ({W{stage[i][0] ^ data_i[i]}} & POLY);
  end
  assign crc_o = stage[W];
endmodule

// File: rtl/page_cursor.sv
module page_cursor #(
  parameter int AW = 7,
  parameter int PW = 5
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          load_i,
  input  logic [AW-1:0] load_addr_i,
  input  logic          adv_i,
  output logic [AW-1:0] addr_o,
  output logic          page_last_o,
  output logic          wrapped_o
);
  // extra msb records carry past the last byte
  logic [AW:0] ptr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      ptr_q <= '0;
    else if (clr_i)   ptr_q <= '0;
    else if (load_i)  ptr_q <= {1'b0, load_addr_i};
    else if (adv_i)   ptr_q <= ptr_q + 1'b1;
  end

  assign addr_o      = ptr_q[AW-1:0];
  assign page_last_o = &ptr_q[PW-1:0];
  assign wrapped_o   = ptr_q[AW];
endmodule

// File: rtl/page_crc_reader.sv
module page_crc_reader
  import page_crc_pkg::*;
#(
  parameter int         PAGE_BYTES = 32,
  parameter int         NUM_PAGES  = 4,
  parameter logic [7:0] READ_OP    = 8'hC3,
  localparam int        MEM_BYTES  = PAGE_BYTES * NUM_PAGES,
  localparam int        AW         = $clog2(MEM_BYTES),
  localparam int        PW         = $clog2(PAGE_BYTES)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          bus_reset_i,
  input  logic          seq_start_i,
  input  logic          rx_valid_i,
  input  logic [7:0]    rx_data_i,
  input  logic          tx_req_i,
  output logic          tx_valid_o,
  output logic [7:0]    tx_data_o,
  output logic          mem_rd_o,
  output logic [AW-1:0] mem_addr_o,
  input  logic [7:0]    mem_data_i
);
  seq_state_e state_q;
  tx_src_e    src_q, src_d;
  logic [7:0] crc_q, crc_rx_nxt, crc_tx_nxt;
  logic       pend_q, accept, bad_q;
  logic       cur_load, cur_adv, page_last, wrapped;
  logic [AW-1:0] cur_addr;

  crc8_lsb #(.W(8), .POLY(CRC_POLY_REFL)) u_crc_rx (
    .crc_i(crc_q), .data_i(rx_data_i), .crc_o(crc_rx_nxt));

  crc8_lsb #(.W(8), .POLY(CRC_POLY_REFL)) u_crc_tx (
    .crc_i(crc_q), .data_i(mem_data_i), .crc_o(crc_tx_nxt));

  page_cursor #(.AW(AW), .PW(PW)) u_cursor (
    .clk_i, .rst_ni,
    .clr_i(bus_reset_i),
    .load_i(cur_load),
    .load_addr_i(rx_data_i[AW-1:0]),
    .adv_i(cur_adv),
    .addr_o(cur_addr),
    .page_last_o(page_last),
    .wrapped_o(wrapped));

  assign accept   = tx_req_i && !pend_q && !bus_reset_i;
  assign cur_load = !bus_reset_i && state_q == ST_ALO && rx_valid_i;
  assign cur_adv  = !bus_reset_i && state_q == ST_DATA && pend_q;

  always_comb begin
    unique case (state_q)
      ST_DATA:          src_d = SRC_MEM;
      ST_HCRC, ST_PCRC: src_d = SRC_CRC;
      default:          src_d = SRC_FILL;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      crc_q   <= '0;
      pend_q  <= 1'b0;
      src_q   <= SRC_FILL;
      bad_q   <= 1'b0;
    end else if (bus_reset_i) begin
      state_q <= ST_IDLE;
      crc_q   <= '0;
      pend_q  <= 1'b0;
      bad_q   <= 1'b0;
    end else begin
      pend_q <= accept;
      if (accept) src_q <= src_d;
      unique case (state_q)
        ST_IDLE: if (seq_start_i) begin
          state_q <= ST_CMD;
          crc_q   <= '0;
        end
        ST_CMD: if (rx_valid_i) begin
          if (rx_data_i == READ_OP) begin
            crc_q   <= crc_rx_nxt;
            state_q <= ST_ALO;
          end else begin
            state_q <= ST_IDLE;
          end
        end
        ST_ALO: if (rx_valid_i) begin
          crc_q   <= crc_rx_nxt;
          bad_q   <= (rx_data_i >> AW) != '0;
          state_q <= ST_AHI;
        end
        ST_AHI: if (rx_valid_i) begin
          crc_q   <= crc_rx_nxt;
          bad_q   <= bad_q | (rx_data_i != '0);
          state_q <= ST_HCRC;
        end
        ST_HCRC: if (pend_q) begin
          crc_q   <= '0;
          state_q <= bad_q ? ST_FILL : ST_DATA;
        end
        ST_DATA: if (pend_q) begin
          crc_q <= crc_tx_nxt;
          if (page_last) state_q <= ST_PCRC;
        end
        ST_PCRC: if (pend_q) begin
          crc_q   <= '0;
          state_q <= wrapped ? ST_DONE : ST_DATA;
        end
        default: ;
      endcase
    end
  end

  assign mem_rd_o   = accept && state_q == ST_DATA;
  assign mem_addr_o = cur_addr;
  assign tx_valid_o = pend_q;

  always_comb begin
    unique case (src_q)
      SRC_MEM: tx_data_o = mem_data_i;
      SRC_CRC: tx_data_o = crc_q;
      default: tx_data_o = 8'hFF;
    endcase
  end
endmodule

// File: rtl/page_crc_reader_chk.sv
module page_crc_reader_chk
  import page_crc_pkg::*;
(
  input logic       clk_i,
  input logic       rst_ni,
  input logic       bus_reset_i,
  input logic       rx_valid_i,
  input logic [7:0] rx_data_i,
  input logic       tx_req_i,
  input logic       tx_valid_o,
  input logic [7:0] tx_data_o,
  input logic       mem_rd_o,
  input seq_state_e state_q
);
  logic lo_bad_q, oor_q;

  // independent record of an out-of-range header
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lo_bad_q <= 1'b0;
      oor_q    <= 1'b0;
    end else if (bus_reset_i) begin
      lo_bad_q <= 1'b0;
      oor_q    <= 1'b0;
    end else if (rx_valid_i && state_q == ST_ALO) begin
      lo_bad_q <= rx_data_i[7];
    end else if (rx_valid_i && state_q == ST_AHI) begin
      oor_q <= lo_bad_q || rx_data_i != 8'h00;
    end
  end

  a_r10_resp_follows_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_req_i && !tx_valid_o && !bus_reset_i |=> tx_valid_o);

  a_r10_no_spurious_resp: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(tx_req_i && !tx_valid_o) |=> !tx_valid_o);

  a_r9_bus_reset_aborts: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_reset_i |=> state_q == ST_IDLE && !tx_valid_o);

  a_r7_done_returns_ff: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == ST_DONE && tx_valid_o |-> tx_data_o == 8'hFF);

  a_r8_no_read_when_oor: assert property (@(posedge clk_i) disable iff (!rst_ni)
    oor_q |-> !mem_rd_o);

  a_r2_bad_opcode_idles: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == ST_CMD && rx_valid_i && rx_data_i != 8'hC3 && !bus_reset_i |=> state_q == ST_IDLE);
endmodule

bind page_crc_reader page_crc_reader_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .bus_reset_i(bus_reset_i),
  .rx_valid_i(rx_valid_i), .rx_data_i(rx_data_i), .tx_req_i(tx_req_i),
  .tx_valid_o(tx_valid_o), .tx_data_o(tx_data_o), .mem_rd_o(mem_rd_o),
  .state_q(state_q));

// File: tb/page_crc_reader_bench.sv
`timescale 1ns/1ps
module page_crc_reader_bench;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       bus_reset_i = 1'b0;
  logic       seq_start_i = 1'b0;
  logic       rx_valid_i = 1'b0;
  logic [7:0] rx_data_i = '0;
  logic       tx_req_i = 1'b0;
  logic       tx_valid_o;
  logic [7:0] tx_data_o;
  logic       mem_rd_o;
  logic [6:0] mem_addr_o;
  logic [7:0] mem_data_i = '0;

  logic [7:0] mem [128];
  int vectors = 0, errors = 0, rd_cnt = 0;
  bit finished = 0;

  always #2.5 clk_i = ~clk_i;

  page_crc_reader u_page_crc_reader (.*);

  always @(posedge clk_i) begin
    if (mem_rd_o) begin
      mem_data_i <= mem[mem_addr_o];
      rd_cnt     <= rd_cnt + 1;
    end
  end

  function automatic logic [7:0] crc8(input logic [7:0] c, input logic [7:0] d);
    logic [7:0] r = c;
    for (int i = 0; i < 8; i++) begin
      logic fb = r[0] ^ d[i];
      r = r >> 1;
      if (fb) r = r ^ 8'h8C;
    end
    return r;
  endfunction

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic send(input logic [7:0] b);
    @(negedge clk_i); rx_valid_i = 1'b1; rx_data_i = b;
    @(negedge clk_i); rx_valid_i = 1'b0;
  endtask

  task automatic arm();
    @(negedge clk_i); seq_start_i = 1'b1;
    @(negedge clk_i); seq_start_i = 1'b0;
  endtask

  task automatic bus_rst();
    @(negedge clk_i); bus_reset_i = 1'b1;
    @(negedge clk_i); bus_reset_i = 1'b0;
    check("R1 valid after bus reset", {7'd0, tx_valid_o}, 8'd0);
  endtask

  task automatic fetch(output logic [7:0] d);
    @(negedge clk_i); tx_req_i = 1'b1;
    @(negedge clk_i); tx_req_i = 1'b0;
    check("R10 response valid", {7'd0, tx_valid_o}, 8'd1);
    d = tx_data_o;
  endtask

  // n responses after the header check byte
  task automatic run_read(input logic [7:0] lo, input logic [7:0] hi, input int n);
    logic [7:0] d, pc;
    int a;
    bit bad, done, emit;
    arm(); send(8'hC3); send(lo); send(hi);
    fetch(d);
    check("R3 header crc", d, crc8(crc8(crc8(8'h00, 8'hC3), lo), hi));
    bad = (hi != 0) || lo[7];
    a = int'(lo[6:0]); pc = 8'h00; done = 0; emit = 0;
    for (int k = 0; k < n; k++) begin
      fetch(d);
      if (bad) check("R8 out of range fill", d, 8'hFF);
      else if (done) check("R7 after last page", d, 8'hFF);
      else if (emit) begin
        check("R5 page crc", d, pc);
        pc = 8'h00; emit = 0;
        if (a == 128) done = 1;
      end else begin
        if (a % 32 == 0 && a != int'(lo)) check("R6 next page data", d, mem[a]);
        else check("R4 data", d, mem[a]);
        pc = crc8(pc, mem[a]);
        if (a % 32 == 31) emit = 1;
        a++;
      end
    end
  endtask

  initial begin
    logic [7:0] d;
    int r0;
    void'($urandom(32'd20240611));
    for (int i = 0; i < 128; i++) mem[i] = 8'($urandom);
    repeat (3) @(negedge clk_i);
    check("R1 valid at reset", {7'd0, tx_valid_o}, 8'd0);
    check("R1 read strobe at reset", {7'd0, mem_rd_o}, 8'd0);
    rst_ni = 1'b1;
    fetch(d); check("R1 idle request", d, 8'hFF);

    run_read(8'h00, 8'h00, 4 * 33 + 3);           // whole array, then R7 fill
    bus_rst(); run_read(8'h2D, 8'h00, 19 + 2 * 33 + 1 + 2);
    bus_rst(); run_read(8'h7F, 8'h00, 4);         // last byte, crc, fill
    bus_rst(); run_read(8'h1F, 8'h00, 5);         // one-byte page

    // R2: wrong opcode
    bus_rst(); arm(); send(8'hF0); send(8'h00); send(8'h00);
    fetch(d); check("R2 wrong opcode", d, 8'hFF);
    fetch(d); check("R2 wrong opcode", d, 8'hFF);
    run_read(8'h40, 8'h00, 3);                     // re-arm without bus reset

    // R8: out-of-range addresses
    bus_rst(); r0 = rd_cnt; run_read(8'h10, 8'h01, 40);
    check("R8 no storage read", 8'(rd_cnt - r0), 8'd0);
    bus_rst(); r0 = rd_cnt; run_read(8'h85, 8'h00, 36);
    check("R8 no storage read", 8'(rd_cnt - r0), 8'd0);

    // R9: abort mid header, retry must give a clean header crc
    bus_rst(); arm(); send(8'hC3); send(8'h05);
    bus_rst(); fetch(d); check("R9 after header abort", d, 8'hFF);
    run_read(8'h05, 8'h00, 6);
    // R9: abort mid data
    bus_rst(); fetch(d); check("R9 after data abort", d, 8'hFF);
    send(8'hC3); fetch(d); check("R9 bytes ignored until start", d, 8'hFF);

    for (int it = 0; it < 25; it++) begin
      bus_rst();
      run_read(8'($urandom % 128), 8'h00, int'($urandom % 150) + 1);
    end
    bus_rst();

    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!finished) begin
      finished = 1;
      vectors++; errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end
endmodule